// File: doc/BRIEF.md
# Folded Four-Element Logic Cluster with Per-Cycle Local Routing

This block is a cluster of four time-multiplexed logic elements. Each element owns a fully programmable selection network. The network picks five signals out of thirteen candidates. The candidates are nine external cluster inputs and the four registered element outputs fed back. Four of the five picked signals address a 4-input lookup table. The fifth can be loaded straight into the element's output register.

Every element keeps one configuration word per folding cycle. A word holds the crosspoint bits, the lookup-table contents and a mode. All four elements read the word chosen by one shared folding-cycle index on every clock. The logic and the local routing of the whole cluster therefore change together, and can change on every cycle.

A write port loads words into the per-element stores. Typically the stores are loaded while the cluster is held in reset. The fold index is then stepped by the surrounding sequencer.

Top module: `mb_cluster`

## Requirements
- R1: While `rst` is high at a rising clock edge, every bit of `cl_out` is 0 after that edge. Reset clears only the element registers and leaves the configuration stores untouched.
- R2: The 13 candidates of each selection network are numbered 0..8 for `ext_in[0]`..`ext_in[8]` and 9..12 for element outputs 0..3. A fed-back element output is the value its register holds in the current cycle.
- R3: A selection output whose 13 crosspoint bits are all clear drives 0.
- R4: When several crosspoints of one selection output are set, the candidate with the lowest number is passed.
- R5: Configuration word layout: bits [64:0] are crosspoints, with bit j*13+i connecting candidate i to selection output j. Bits [80:65] are the lookup table. Bits [82:81] are the mode. In mode 01 the element loads table bit {s3,s2,s1,s0}, where sj is selection output j.
- R6: In mode 10 the element loads selection output 4.
- R7: In modes 00 and 11 the element keeps its value, whatever the crosspoints and table hold.
- R8: On every clock each element uses its own word stored at slot `fold_idx`, and all four elements use the same slot. Switching `fold_idx` from one cycle to the next switches routing and logic at once.
- R9: A write with `cfg_we` high stores `cfg_word` into slot `cfg_slot` of element `cfg_le` only. It is accepted during reset as well. The new word governs edges after the write edge. The edge of the write itself still uses the old word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset of the element registers |
| ext_in | input | 9 | External cluster inputs, candidates 0..8 |
| fold_idx | input | 3 | Shared folding-cycle index selecting the active slot |
| cfg_we | input | 1 | Configuration write enable |
| cfg_le | input | 2 | Element addressed by the write |
| cfg_slot | input | 3 | Folding slot addressed by the write |
| cfg_word | input | 83 | Configuration word to store |
| cl_out | output | 4 | Registered element outputs |

## Verification
The hardest situation to reach is one where routing, logic and feedback all change between consecutive cycles. In that situation an element's result depends on what another element computed under a different slot one cycle earlier. A second hard case is a write landing on the slot that is in use on that very edge. The stimulus first loads hand-built slots, covering external routing, feedback rotation, empty outputs, competing crosspoints, full lookup tables and hold modes. It then steps the fold index freely across all slots while random writes keep rewriting the stores, including the active slot. A behavioural model follows every edge throughout.

// File: rtl/mb_pkg.sv
package mb_pkg;
  typedef enum logic [1:0] {
    MODE_HOLD     = 2'b00,
    MODE_LUT      = 2'b01,
    MODE_DIRECT   = 2'b10,
    MODE_HOLD_ALT = 2'b11
  } le_mode_e;
endpackage

// File: rtl/mb_cfg_store.sv
module mb_cfg_store #(
  parameter int N_LE   = 4,
  parameter int N_FOLD = 8,
  parameter int CFG_W  = 83,
  localparam int FOLD_W = (N_FOLD > 1) ? $clog2(N_FOLD) : 1,
  localparam int LE_W   = (N_LE > 1) ? $clog2(N_LE) : 1
) (
  input  logic              clk,
  input  logic              we,
  input  logic [LE_W-1:0]   wr_le,
  input  logic [FOLD_W-1:0] wr_slot,
  input  logic [CFG_W-1:0]  wr_data,
  input  logic [FOLD_W-1:0] rd_slot,
  output logic [CFG_W-1:0]  rd_data [N_LE]
);
  // One small RAM per element: synchronous write, asynchronous read.
  for (genvar e = 0; e < N_LE; e++) begin : g_bank
    logic [CFG_W-1:0] mem [N_FOLD];

    always_ff @(posedge clk) begin
      if (we && (wr_le == LE_W'(e))) begin
        mem[wr_slot] <= wr_data;
      end
    end

    assign rd_data[e] = mem[rd_slot];
  end
endmodule

// File: rtl/mb_xbar.sv
module mb_xbar #(
  parameter int N_CAND = 13,
  parameter int N_SEL  = 5
) (
  input  logic [N_CAND*N_SEL-1:0] xcfg,
  input  logic [N_CAND-1:0]       cand,
  output logic [N_SEL-1:0]        sel
);
  // One crosspoint bit per candidate and output.
  // The lowest-numbered enabled candidate wins; no enabled candidate gives 0.
  always_comb begin
    for (int j = 0; j < N_SEL; j++) begin
      sel[j] = 1'b0;
      for (int i = N_CAND - 1; i >= 0; i--) begin
        if (xcfg[j*N_CAND + i]) begin
          sel[j] = cand[i];
        end
      end
    end
  end
endmodule

// File: rtl/mb_le.sv
module mb_le
  import mb_pkg::*;
#(
  parameter int K = 4,
  localparam int LUT_W = 2**K
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [1:0]       mode,
  input  logic [LUT_W-1:0] lut,
  input  logic [K:0]       xsel,
  output logic             q
);
  logic lut_bit;

  assign lut_bit = lut[xsel[K-1:0]];

  always_ff @(posedge clk) begin
    if (rst) begin
      q <= 1'b0;
    end else begin
      case (le_mode_e'(mode))
        MODE_LUT:    q <= lut_bit;
        MODE_DIRECT: q <= xsel[K];
        default:     q <= q;
      endcase
    end
  end
endmodule

// File: rtl/mb_cluster.sv
module mb_cluster #(
  parameter int N_LE   = 4,
  parameter int N_EXT  = 9,
  parameter int LUT_K  = 4,
  parameter int N_FOLD = 8,
  localparam int N_SEL  = LUT_K + 1,
  localparam int N_CAND = N_EXT + N_LE,
  localparam int XBAR_W = N_CAND * N_SEL,
  localparam int LUT_W  = 2**LUT_K,
  localparam int CFG_W  = XBAR_W + LUT_W + 2,
  localparam int FOLD_W = (N_FOLD > 1) ? $clog2(N_FOLD) : 1,
  localparam int LE_W   = (N_LE > 1) ? $clog2(N_LE) : 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [N_EXT-1:0]  ext_in,
  input  logic [FOLD_W-1:0] fold_idx,
  input  logic              cfg_we,
  input  logic [LE_W-1:0]   cfg_le,
  input  logic [FOLD_W-1:0] cfg_slot,
  input  logic [CFG_W-1:0]  cfg_word,
  output logic [N_LE-1:0]   cl_out
);
  logic [CFG_W-1:0]  cfg_cur [N_LE];
  logic [N_LE-1:0]   le_q;
  logic [N_CAND-1:0] cand;
  logic [XBAR_W-1:0] xcfg_a [N_LE];
  logic [LUT_W-1:0]  lut_a  [N_LE];
  logic [1:0]        mode_a [N_LE];
  logic [N_SEL-1:0]  xsel_a [N_LE];

  mb_cfg_store #(.N_LE(N_LE), .N_FOLD(N_FOLD), .CFG_W(CFG_W)) u_store (
    .clk     (clk),
    .we      (cfg_we),
    .wr_le   (cfg_le),
    .wr_slot (cfg_slot),
    .wr_data (cfg_word),
    .rd_slot (fold_idx),
    .rd_data (cfg_cur)
  );

  // Candidate numbering: external inputs first, then element outputs.
  assign cand = {le_q, ext_in};

  for (genvar e = 0; e < N_LE; e++) begin : g_le
    assign xcfg_a[e] = cfg_cur[e][XBAR_W-1:0];
    assign lut_a[e]  = cfg_cur[e][XBAR_W +: LUT_W];
    assign mode_a[e] = cfg_cur[e][CFG_W-1 -: 2];

    mb_xbar #(.N_CAND(N_CAND), .N_SEL(N_SEL)) u_xbar (
      .xcfg (xcfg_a[e]),
      .cand (cand),
      .sel  (xsel_a[e])
    );

    mb_le #(.K(LUT_K)) u_le (
      .clk  (clk),
      .rst  (rst),
      .mode (mode_a[e]),
      .lut  (lut_a[e]),
      .xsel (xsel_a[e]),
      .q    (le_q[e])
    );
  end

  assign cl_out = le_q;
endmodule

// File: rtl/mb_cluster_chk.sv
module mb_cluster_chk #(
  parameter int N_LE   = 4,
  parameter int N_CAND = 13,
  parameter int N_SEL  = 5
) (
  input logic                    clk,
  input logic                    rst,
  input logic [N_LE-1:0]         q,
  input logic [1:0]              mode_a [N_LE],
  input logic [N_SEL-1:0]        xsel_a [N_LE],
  input logic [N_CAND*N_SEL-1:0] xcfg_a [N_LE]
);
  // R1
  a_r1_reset_clears: assert property (@(posedge clk) rst |=> (q == '0));

  for (genvar e = 0; e < N_LE; e++) begin : g_e
    // R7
    a_r7_hold_keeps: assert property (@(posedge clk) disable iff (rst)
      (mode_a[e] == 2'b00 || mode_a[e] == 2'b11) |=> (q[e] == $past(q[e])));
    // R6
    a_r6_direct_load: assert property (@(posedge clk) disable iff (rst)
      (mode_a[e] == 2'b10) |=> (q[e] == $past(xsel_a[e][N_SEL-1])));
    for (genvar j = 0; j < N_SEL; j++) begin : g_j
      // R3
      a_r3_empty_zero: assert property (@(posedge clk) disable iff (rst)
        (xcfg_a[e][j*N_CAND +: N_CAND] == '0) |-> (xsel_a[e][j] == 1'b0));
    end
  end
endmodule

bind mb_cluster mb_cluster_chk #(.N_LE(N_LE), .N_CAND(N_CAND), .N_SEL(N_SEL)) u_chk (
  .clk    (clk),
  .rst    (rst),
  .q      (cl_out),
  .mode_a (mode_a),
  .xsel_a (xsel_a),
  .xcfg_a (xcfg_a)
);

// File: tb/test_mb_cluster.sv
module test_mb_cluster;
  localparam int N_LE = 4, N_EXT = 9, LUT_K = 4, N_FOLD = 8;
  localparam int N_SEL = LUT_K + 1, N_CAND = N_EXT + N_LE;
  localparam int XBAR_W = N_CAND * N_SEL, LUT_W = 2**LUT_K;
  localparam int CFG_W = XBAR_W + LUT_W + 2;
  localparam int FOLD_W = 3, LE_W = 2;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [N_EXT-1:0]  ext_in = '0;
  logic [FOLD_W-1:0] fold_idx = '0;
  logic cfg_we = 1'b0;
  logic [LE_W-1:0]   cfg_le = '0;
  logic [FOLD_W-1:0] cfg_slot = '0;
  logic [CFG_W-1:0]  cfg_word = '0;
  logic [N_LE-1:0]   cl_out;

  mb_cluster i_mb_cluster (
    .clk(clk), .rst(rst), .ext_in(ext_in), .fold_idx(fold_idx),
    .cfg_we(cfg_we), .cfg_le(cfg_le), .cfg_slot(cfg_slot),
    .cfg_word(cfg_word), .cl_out(cl_out)
  );

  always #10 clk = ~clk;

  logic [CFG_W-1:0] m_mem [N_LE][N_FOLD];
  logic [N_LE-1:0]  m_q = '0;
  int checks = 0, failures = 0;
  bit done = 0;
  string req = "R1";

  function automatic logic pick(logic [CFG_W-1:0] w, logic [N_CAND-1:0] c, int j);
    for (int i = 0; i < N_CAND; i++) if (w[j*N_CAND + i]) return c[i];
    return 1'b0;
  endfunction

  function automatic logic [CFG_W-1:0] mk(logic [1:0] mode, logic [LUT_W-1:0] lut,
                                          logic [XBAR_W-1:0] xb);
    return {mode, lut, xb};
  endfunction

  function automatic logic [XBAR_W-1:0] xp(int j, int i);
    logic [XBAR_W-1:0] v = '0;
    v[j*N_CAND + i] = 1'b1;
    return v;
  endfunction

  // One clock: drive at a negedge, advance the model, check at the next negedge.
  task automatic cyc(input logic r, input logic [N_EXT-1:0] x, input logic [FOLD_W-1:0] f,
                     input logic we, input logic [LE_W-1:0] le,
                     input logic [FOLD_W-1:0] sl, input logic [CFG_W-1:0] wd);
    logic [N_LE-1:0] nxt;
    logic [N_CAND-1:0] c;
    rst = r; ext_in = x; fold_idx = f; cfg_we = we; cfg_le = le; cfg_slot = sl; cfg_word = wd;
    c = {m_q, x};
    nxt = m_q;
    for (int e = 0; e < N_LE; e++) begin
      logic [CFG_W-1:0] w;
      logic [3:0] a;
      w = m_mem[e][f];
      for (int j = 0; j < 4; j++) a[j] = pick(w, c, j);
      case (w[CFG_W-1 -: 2])
        2'b01: nxt[e] = w[XBAR_W + int'(a)];
        2'b10: nxt[e] = pick(w, c, 4);
        default: nxt[e] = m_q[e];
      endcase
    end
    if (r) nxt = '0;
    if (we) m_mem[le][sl] = wd;
    m_q = nxt;
    @(negedge clk);
    checks++;
    if (cl_out !== m_q) begin
      failures++;
      $display("FAIL %s: cl_out=%b expected=%b", req, cl_out, m_q);
    end
  endtask

  task automatic run(input logic [N_EXT-1:0] x, input logic [FOLD_W-1:0] f);
    cyc(1'b0, x, f, 1'b0, '0, '0, '0);
  endtask

  task automatic load(input int le, input int sl, input logic [CFG_W-1:0] wd);
    cyc(1'b1, '0, '0, 1'b1, LE_W'(le), FOLD_W'(sl), wd);
  endtask

  function automatic logic [CFG_W-1:0] rnd_word();
    logic [95:0] r = {$urandom(), $urandom(), $urandom()};
    return r[CFG_W-1:0];
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1;
      failures++;
      $display("FAIL watchdog: run did not complete, expected completion");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    @(negedge clk);
    // R1 and R9: configuration loaded under reset, outputs stay 0.
    req = "R1/R9 load under reset";
    for (int e = 0; e < N_LE; e++) begin
      load(e, 0, mk(2'b10, '0, xp(4, e)));                                // R2 ext route
      load(e, 1, mk(2'b10, '0, xp(4, 9 + (e + 1) % 4)));                  // R2 feedback
      load(e, 2, mk(2'b01, (e == 0) ? 16'h0001 : 16'hFFFE, '0));          // R3
      load(e, 3, mk(2'b10, '0, xp(4, e + 2) | xp(4, 8) | xp(4, 12)));     // R4
      load(e, 4, mk(2'b01, (e == 0) ? 16'h6996 : (e == 1) ? 16'h8000 :
                           (e == 2) ? 16'hFFFE : 16'hCACA,
                   xp(0, 0) | xp(1, 1) | xp(2, 2) | xp(3, 3)));           // R5
      load(e, 5, mk((e < 2) ? 2'b00 : 2'b11, 16'hFFFF, '1));              // R7
      load(e, 6, rnd_word());
      load(e, 7, rnd_word());
    end
    req = "R2/R6 external routing";
    for (int k = 0; k < 20; k++) run(N_EXT'($urandom()), 3'd0);
    req = "R2 feedback rotation";
    run(9'h001, 3'd0);
    for (int k = 0; k < 8; k++) run(N_EXT'($urandom()), 3'd1);
    req = "R3 empty crosspoints";
    for (int k = 0; k < 5; k++) run(N_EXT'($urandom()), 3'd2);
    req = "R4 lowest candidate wins";
    for (int k = 0; k < 24; k++) run(N_EXT'($urandom()), 3'd3);
    req = "R5 lookup table";
    for (int k = 0; k < 16; k++) run(N_EXT'(k) | (N_EXT'($urandom()) & 9'h1F0), 3'd4);
    req = "R7 hold modes";
    run(9'h00A, 3'd0);
    for (int k = 0; k < 8; k++) run(N_EXT'($urandom()), 3'd5);
    req = "R8 per-cycle slot switching";
    for (int k = 0; k < 60; k++) run(N_EXT'($urandom()), FOLD_W'($urandom_range(0, 5)));
    req = "R9 write to active slot";
    cyc(1'b0, 9'h1FF, 3'd4, 1'b1, 2'd2, 3'd4, mk(2'b10, '0, xp(4, 0)));
    run(9'h000, 3'd4);
    run(9'h001, 3'd4);
    cyc(1'b0, 9'h0F0, 3'd4, 1'b1, 2'd0, 3'd6, mk(2'b10, '0, xp(4, 1)));
    run(9'h0F3, 3'd4);
    req = "R8/R9 random operation";
    for (int k = 0; k < 400; k++) begin
      if ($urandom_range(0, 3) == 0)
        cyc(1'b0, N_EXT'($urandom()), FOLD_W'($urandom()), 1'b1,
            LE_W'($urandom()), FOLD_W'($urandom()), rnd_word());
      else
        run(N_EXT'($urandom()), FOLD_W'($urandom()));
    end
    req = "R1 reset mid-run";
    cyc(1'b1, 9'h1FF, 3'd0, 1'b0, '0, '0, '0);
    cyc(1'b1, 9'h1FF, 3'd1, 1'b0, '0, '0, '0);
    req = "R1 store kept after reset";
    for (int k = 0; k < 10; k++) run(N_EXT'($urandom()), FOLD_W'($urandom()));
    done = 1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule